// File: doc/BRIEF.md
# Capture, Compare and Bridge PWM Channel

This block is one timer-referenced peripheral channel. A 4-bit mode input picks what it does. In capture modes it copies an external 16-bit timer count into a holding register when selected input edges arrive, and it can count several edges before each capture. In compare modes it watches for the timer count to equal a reference value and then drives a pin, raises an event, or asks for a timer reset and a conversion start. In PWM modes it turns a 10-bit duty value into a modulated waveform. That waveform drives one pin, a dead-banded complementary pin pair, or a four-pin full bridge in either direction. Each of the two pin pairs has its own polarity.

The timers sit outside the block. For capture and compare, the surrounding logic supplies the 16-bit timer count. For PWM, it supplies a 10-bit timebase count and a one-cycle period-match pulse. The upper 8 bits of that count are the timebase and the lower 2 bits are its sub-cycle fraction. The interrupt flag, timer-reset request and conversion-start outputs are one-cycle pulses.

Top module: `capcmp_unit`

## Requirements
- R1: Modes 0000, 0001 and 0011 are disabled. In these modes all pins are 0 and no pulse output is raised. Entering them clears the edge prescale count, the compare pin level and the latched PWM duty, so a later PWM mode produces no high time until a period match loads a new duty.
- R2: Mode 0101 captures on each rising edge of the capture input and mode 0100 captures on each falling edge. At the clock edge where the capture input has changed, the timer value is copied to `cap_val_o` and `irq_o` is high for the following cycle only. An edge of the opposite direction does nothing.
- R3: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. Edges in between raise no flag and leave `cap_val_o` unchanged.
- R4: Any change of `mode_i` clears the edge prescale count. Edges counted before the change do not count toward a capture afterwards.
- R5: A compare match is the cycle in which `tmr_i` first equals `ref_i`. A timer that holds the same value does not match again. Mode 0010 inverts pin A at each match and raises `irq_o`. On entry to mode 0010, pin A is 0.
- R6: Mode 1000 sets pin A to 0 on entry and to 1 at a match. Mode 1001 sets pin A to 1 on entry and to 0 at a match. Both raise `irq_o` on the match.
- R7: Mode 1010 raises only `irq_o` at a match and keeps the pins at 0. Mode 1011 also pulses `tmr_rst_o` and `adc_start_o` for that same single cycle.
- R8: In PWM modes (11xx), the duty is {`duty_hi_i`, `duty_lo_i`}, a 10-bit value. It is latched only at a clock edge where `period_i` is high. The modulated signal is active one cycle after `pwm_cnt_i` is presented, whenever that count is below the latched duty.
- R9: Mode bit 1 makes pins A and C active-low and mode bit 0 makes pins B and D active-low. Their clear values mean active-high. Pin order in `pin_o` is A=bit 0, B=bit 1, C=bit 2, D=bit 3.
- R10: `arr_i` 00 drives only pin A, modulated, and leaves the other pins 0. `arr_i` 01 holds A active, B and C inactive, and modulates D. `arr_i` 11 holds C active, A and D inactive, and modulates B.
- R11: `arr_i` 10 drives A with the modulated signal and B with its complement. After each change of the modulated signal, both are inactive for exactly `dead_i` cycles. With `dead_i` equal to 0 the switch is immediate.
- R12: In capture modes, and in compare modes 1010 and 1011, all pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 4 | Function select |
| arr_i | input | 2 | PWM output arrangement |
| tmr_i | input | 16 | External timer count for capture and compare |
| ref_i | input | 16 | Compare reference value |
| cap_pin_i | input | 1 | Capture input, already synchronised |
| pwm_cnt_i | input | 10 | PWM timebase count with 2 fraction bits |
| period_i | input | 1 | PWM period match pulse |
| duty_hi_i | input | 8 | Upper duty bits |
| duty_lo_i | input | 2 | Lower duty bits |
| dead_i | input | 4 | Half-bridge dead band in cycles |
| pin_o | output | 4 | Pin drives A, B, C, D in bits 0 to 3 |
| cap_val_o | output | 16 | Captured timer value |
| irq_o | output | 1 | Interrupt flag pulse |
| tmr_rst_o | output | 1 | Timer reset request pulse |
| adc_start_o | output | 1 | Conversion start pulse |

## Verification
The bench uses the default parameters: a 16-bit timer, an 8+2 bit duty, a 4-bit dead band, and prescale points of 4 and 16. With these values a full divide-by-16 capture run and several whole PWM periods fit in a short test. The 10-bit duty reaches both extremes: a duty of 0 never goes active, and a duty of 1023 is active for every count but the last. The 4-bit dead band lets the bench step through 3-cycle gaps one cycle at a time and compare them with the zero-gap case.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    typedef enum logic [1:0] {
        FN_OFF = 2'd0,
        FN_CAP = 2'd1,
        FN_CMP = 2'd2,
        FN_PWM = 2'd3
    } func_e;

    // PWM pin arrangement codes
    localparam logic [1:0] ARR_SINGLE = 2'b00;
    localparam logic [1:0] ARR_FWD    = 2'b01;
    localparam logic [1:0] ARR_HALF   = 2'b10;
    localparam logic [1:0] ARR_REV    = 2'b11;

    function automatic func_e decode_func(input logic [3:0] m);
        func_e f;
        casez (m)
            4'b0010: f = FN_CMP;
            4'b01??: f = FN_CAP;
            4'b10??: f = FN_CMP;
            4'b11??: f = FN_PWM;
            default: f = FN_OFF;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/capcmp_capture.sv
module capcmp_capture #(
    parameter int TMR_W  = 16,
    parameter int PS_MID = 4,
    parameter int PS_MAX = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             active_i,
    input  logic             restart_i,
    input  logic [1:0]       sel_i,
    input  logic             pin_i,
    input  logic [TMR_W-1:0] tmr_i,
    output logic [TMR_W-1:0] cap_o,
    output logic             evt_o
);
    localparam int CNT_W = $clog2(PS_MAX);

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic [TMR_W-1:0] cap;
        logic             evt;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic [CNT_W-1:0] last;
    logic             hit;

    always_comb begin
        case (sel_i)
            2'b10:   last = CNT_W'(PS_MID - 1);
            2'b11:   last = CNT_W'(PS_MAX - 1);
            default: last = '0;
        endcase
        hit = (sel_i == 2'b00) ? (st_q.prev & ~pin_i) : (~st_q.prev & pin_i);

        st_d      = st_q;
        st_d.prev = pin_i;
        st_d.evt  = 1'b0;
        if (!active_i || restart_i) begin
            st_d.cnt = '0;
        end else if (hit) begin
            if (st_q.cnt == last) begin
                st_d.cnt = '0;
                st_d.cap = tmr_i;
                st_d.evt = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cap_o = st_q.cap;
    assign evt_o = st_q.evt;
endmodule

// File: rtl/capcmp_compare.sv
module capcmp_compare #(
    parameter int TMR_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             active_i,
    input  logic             restart_i,
    input  logic [3:0]       mode_i,
    input  logic [TMR_W-1:0] tmr_i,
    input  logic [TMR_W-1:0] ref_i,
    output logic             pin_o,
    output logic             evt_o,
    output logic             trig_o
);
    typedef struct packed {
        logic mq;
        logic pin;
        logic evt;
        logic trig;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       match;

    always_comb begin
        match     = (tmr_i == ref_i);
        st_d      = st_q;
        st_d.mq   = match;
        st_d.evt  = 1'b0;
        st_d.trig = 1'b0;
        if (!active_i) begin
            st_d.pin = 1'b0;
        end else if (restart_i) begin
            st_d.pin = (mode_i == 4'b1001);
        end else if (match && !st_q.mq) begin
            st_d.evt = 1'b1;
            case (mode_i)
                4'b0010: st_d.pin  = ~st_q.pin;
                4'b1000: st_d.pin  = 1'b1;
                4'b1001: st_d.pin  = 1'b0;
                4'b1011: st_d.trig = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pin_o  = st_q.pin;
    assign evt_o  = st_q.evt;
    assign trig_o = st_q.trig;
endmodule

// File: rtl/capcmp_pwm.sv
module capcmp_pwm
    import capcmp_pkg::*;
#(
    parameter int DHI_W = 8,
    parameter int DLO_W = 2,
    parameter int DB_W  = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   active_i,
    input  logic                   pol_ac_i,
    input  logic                   pol_bd_i,
    input  logic [1:0]             arr_i,
    input  logic [DHI_W+DLO_W-1:0] cnt_i,
    input  logic                   period_i,
    input  logic [DHI_W-1:0]       duty_hi_i,
    input  logic [DLO_W-1:0]       duty_lo_i,
    input  logic [DB_W-1:0]        dead_i,
    output logic [3:0]             pins_o
);
    localparam int DUTY_W = DHI_W + DLO_W;

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        logic              last_raw;
        logic [DB_W-1:0]   dbc;
        logic [3:0]        act;
    } pwm_state_t;

    pwm_state_t st_d, st_q;
    logic       raw;
    logic [3:0] en;
    logic [3:0] pol;

    always_comb begin
        raw           = (cnt_i < st_q.duty);
        st_d          = st_q;
        st_d.last_raw = raw;
        st_d.dbc      = '0;
        if (period_i) st_d.duty = {duty_hi_i, duty_lo_i};

        case (arr_i)
            ARR_SINGLE: st_d.act = {3'b000, raw};
            ARR_FWD:    st_d.act = {raw, 1'b0, 1'b0, 1'b1};
            ARR_REV:    st_d.act = {1'b0, 1'b1, raw, 1'b0};
            default: begin
                if (raw != st_q.last_raw) begin
                    if (dead_i == '0) begin
                        st_d.act = {2'b00, ~raw, raw};
                    end else begin
                        st_d.act = 4'b0000;
                        st_d.dbc = dead_i;
                    end
                end else if (st_q.dbc > DB_W'(1)) begin
                    st_d.act = 4'b0000;
                    st_d.dbc = st_q.dbc - 1'b1;
                end else begin
                    st_d.act = {2'b00, ~raw, raw};
                end
            end
        endcase

        if (!active_i) st_d = '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        case (arr_i)
            ARR_SINGLE: en = 4'b0001;
            ARR_HALF:   en = 4'b0011;
            default:    en = 4'b1111;
        endcase
        pol    = {pol_bd_i, pol_ac_i, pol_bd_i, pol_ac_i};
        pins_o = (st_q.act ^ pol) & en;
    end
endmodule

// File: rtl/capcmp_unit.sv
module capcmp_unit
    import capcmp_pkg::*;
#(
    parameter int TMR_W  = 16,
    parameter int DHI_W  = 8,
    parameter int DLO_W  = 2,
    parameter int DB_W   = 4,
    parameter int PS_MID = 4,
    parameter int PS_MAX = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [3:0]             mode_i,
    input  logic [1:0]             arr_i,
    input  logic [TMR_W-1:0]       tmr_i,
    input  logic [TMR_W-1:0]       ref_i,
    input  logic                   cap_pin_i,
    input  logic [DHI_W+DLO_W-1:0] pwm_cnt_i,
    input  logic                   period_i,
    input  logic [DHI_W-1:0]       duty_hi_i,
    input  logic [DLO_W-1:0]       duty_lo_i,
    input  logic [DB_W-1:0]        dead_i,
    output logic [3:0]             pin_o,
    output logic [TMR_W-1:0]       cap_val_o,
    output logic                   irq_o,
    output logic                   tmr_rst_o,
    output logic                   adc_start_o
);
    typedef struct packed {
        logic [3:0] mode;
    } top_state_t;

    top_state_t st_d, st_q;
    func_e      fn;
    logic       restart;
    logic       cap_evt, cmp_evt, cmp_trig, cmp_pin;
    logic [3:0] pwm_pins;

    always_comb begin
        fn        = decode_func(mode_i);
        restart   = (mode_i != st_q.mode);
        st_d.mode = mode_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    capcmp_capture #(.TMR_W(TMR_W), .PS_MID(PS_MID), .PS_MAX(PS_MAX)) u_cap (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .active_i  (fn == FN_CAP),
        .restart_i (restart),
        .sel_i     (mode_i[1:0]),
        .pin_i     (cap_pin_i),
        .tmr_i     (tmr_i),
        .cap_o     (cap_val_o),
        .evt_o     (cap_evt)
    );

    capcmp_compare #(.TMR_W(TMR_W)) u_cmp (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .active_i  (fn == FN_CMP),
        .restart_i (restart),
        .mode_i    (mode_i),
        .tmr_i     (tmr_i),
        .ref_i     (ref_i),
        .pin_o     (cmp_pin),
        .evt_o     (cmp_evt),
        .trig_o    (cmp_trig)
    );

    capcmp_pwm #(.DHI_W(DHI_W), .DLO_W(DLO_W), .DB_W(DB_W)) u_pwm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .active_i  (fn == FN_PWM),
        .pol_ac_i  (mode_i[1]),
        .pol_bd_i  (mode_i[0]),
        .arr_i     (arr_i),
        .cnt_i     (pwm_cnt_i),
        .period_i  (period_i),
        .duty_hi_i (duty_hi_i),
        .duty_lo_i (duty_lo_i),
        .dead_i    (dead_i),
        .pins_o    (pwm_pins)
    );

    always_comb begin
        case (fn)
            FN_CMP: begin
                pin_o = 4'b0000;
                if (mode_i == 4'b0010 || mode_i == 4'b1000 || mode_i == 4'b1001)
                    pin_o[0] = cmp_pin;
            end
            FN_PWM:  pin_o = pwm_pins;
            default: pin_o = 4'b0000;
        endcase
        irq_o       = cap_evt | cmp_evt;
        tmr_rst_o   = cmp_trig;
        adc_start_o = cmp_trig;
    end
endmodule

// File: rtl/capcmp_unit_chk.sv
module capcmp_unit_chk
    import capcmp_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic [3:0] mode_i,
    input logic [1:0] arr_i,
    input logic [3:0] pin_o,
    input logic       irq_o,
    input logic       tmr_rst_o,
    input logic       adc_start_o
);
    logic off_now, cap_now, pwm_now;
    assign off_now = (decode_func(mode_i) == FN_OFF);
    assign cap_now = (decode_func(mode_i) == FN_CAP);
    assign pwm_now = (decode_func(mode_i) == FN_PWM);

    a_r1_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (off_now && $past(off_now)) |-> (pin_o == 4'b0000 && !irq_o && !tmr_rst_o && !adc_start_o));

    a_r12_capture_pins_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_now |-> (pin_o == 4'b0000));

    a_r6_set_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 4'b1000 && $stable(mode_i) && irq_o) |-> pin_o[0]);

    a_r7_trigger_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmr_rst_o |-> (irq_o && adc_start_o));

    a_r11_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwm_now && arr_i == ARR_HALF && $stable(mode_i) && $stable(arr_i))
        |-> !((pin_o[0] ^ mode_i[1]) && (pin_o[1] ^ mode_i[0])));

    a_r10_forward_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwm_now && arr_i == ARR_FWD && $stable(mode_i) && $stable(arr_i))
        |-> ((pin_o[0] ^ mode_i[1]) && !(pin_o[1] ^ mode_i[0]) && !(pin_o[2] ^ mode_i[1])));
endmodule

bind capcmp_unit capcmp_unit_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .arr_i       (arr_i),
    .pin_o       (pin_o),
    .irq_o       (irq_o),
    .tmr_rst_o   (tmr_rst_o),
    .adc_start_o (adc_start_o)
);

// File: tb/capcmp_unit_test.sv
module capcmp_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = 4'b0000;
    logic [1:0]  arr = 2'b00;
    logic [15:0] tmr = '0;
    logic [15:0] refv = '0;
    logic        cap_pin = 1'b0;
    logic [9:0]  pcnt = '0;
    logic        period = 1'b0;
    logic [7:0]  dhi = '0;
    logic [1:0]  dlo = '0;
    logic [3:0]  dead = '0;
    logic [3:0]  pin;
    logic [15:0] cap_val;
    logic        irq, trst, adcs;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    capcmp_unit uut (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .arr_i(arr),
        .tmr_i(tmr), .ref_i(refv), .cap_pin_i(cap_pin),
        .pwm_cnt_i(pcnt), .period_i(period), .duty_hi_i(dhi), .duty_lo_i(dlo),
        .dead_i(dead), .pin_o(pin), .cap_val_o(cap_val), .irq_o(irq),
        .tmr_rst_o(trst), .adc_start_o(adcs)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input logic [3:0] m);
        mode = m;
        cyc();
    endtask

    task automatic rise(input logic [15:0] t);
        tmr = t; cap_pin = 1'b1; cyc();
    endtask

    task automatic fall(input logic [15:0] t);
        tmr = t; cap_pin = 1'b0; cyc();
    endtask

    task automatic load_duty(input logic [7:0] h, input logic [1:0] l);
        dhi = h; dlo = l; period = 1'b1; pcnt = 10'h3FF; cyc();
        period = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset pins", pin, 0);
        check("R1 reset irq", irq, 0);
        check("R1 reset trst", trst, 0);
        check("R1 reset adc", adcs, 0);
        check("R2 reset capture value", cap_val, 0);
    endtask

    task automatic t_single_edge();
        set_mode(4'b0101);
        rise(16'h1234);
        check("R2 rise flag", irq, 1);
        check("R2 rise value", cap_val, 16'h1234);
        check("R12 capture pins", pin, 0);
        cyc();
        check("R2 flag one cycle", irq, 0);
        fall(16'h2222);
        check("R2 falling ignored in rise mode", irq, 0);
        set_mode(4'b0100);
        rise(16'h0ABC);
        check("R2 rising ignored in fall mode", irq, 0);
        fall(16'h0ABD);
        check("R2 fall flag", irq, 1);
        check("R2 fall value", cap_val, 16'h0ABD);
    endtask

    task automatic t_prescale();
        set_mode(4'b0110);
        for (int i = 1; i <= 4; i++) begin
            rise(16'h0100 + 16'(i));
            check("R3 div4 flag", irq, (i == 4) ? 1 : 0);
            fall(16'h0);
        end
        check("R3 div4 value", cap_val, 16'h0104);
        set_mode(4'b0111);
        for (int i = 1; i <= 16; i++) begin
            rise(16'h0200 + 16'(i));
            check("R3 div16 flag", irq, (i == 16) ? 1 : 0);
            fall(16'h0);
        end
        check("R3 div16 value", cap_val, 16'h0210);
    endtask

    task automatic t_mode_change();
        set_mode(4'b0111);
        for (int i = 0; i < 3; i++) begin rise(16'h0300); fall(16'h0); end
        set_mode(4'b0110);
        for (int i = 1; i <= 4; i++) begin
            rise(16'h0400 + 16'(i));
            check("R4 count cleared on mode change", irq, (i == 4) ? 1 : 0);
            fall(16'h0);
        end
        set_mode(4'b0110);
        for (int i = 0; i < 2; i++) begin rise(16'h0500); fall(16'h0); end
        set_mode(4'b0011);
        rise(16'h0600);
        check("R1 reserved mode no capture", irq, 0);
        check("R1 reserved mode pins", pin, 0);
        fall(16'h0);
        set_mode(4'b0110);
        for (int i = 1; i <= 4; i++) begin
            rise(16'h0700 + 16'(i));
            check("R1 prescale cleared by disable", irq, (i == 4) ? 1 : 0);
            fall(16'h0);
        end
    endtask

    task automatic t_compare();
        refv = 16'h0050; tmr = 16'h0010;
        set_mode(4'b0010);
        check("R5 toggle entry low", pin, 0);
        tmr = 16'h0050; cyc();
        check("R5 toggle high", pin, 1);
        check("R5 toggle flag", irq, 1);
        cyc();
        check("R5 held timer no rematch", irq, 0);
        check("R5 held level", pin, 1);
        tmr = 16'h0051; cyc();
        tmr = 16'h0050; cyc();
        check("R5 toggle back", pin, 0);
        tmr = 16'h0010;
        set_mode(4'b1000);
        check("R6 set mode entry low", pin, 0);
        tmr = 16'h0050; cyc();
        check("R6 set on match", pin, 1);
        check("R6 set flag", irq, 1);
        tmr = 16'h0010;
        set_mode(4'b1001);
        check("R6 clear mode entry high", pin, 1);
        tmr = 16'h0050; cyc();
        check("R6 clear on match", pin, 0);
        check("R6 clear flag", irq, 1);
        tmr = 16'h0010;
        set_mode(4'b1010);
        tmr = 16'h0050; cyc();
        check("R7 flag only", irq, 1);
        check("R7 no timer reset", trst, 0);
        check("R7 no conversion", adcs, 0);
        check("R12 flag-only pins low", pin, 0);
        tmr = 16'h0010;
        set_mode(4'b1011);
        tmr = 16'h0050; cyc();
        check("R7 trigger flag", irq, 1);
        check("R7 timer reset pulse", trst, 1);
        check("R7 conversion pulse", adcs, 1);
        cyc();
        check("R7 timer reset single cycle", trst, 0);
        check("R7 conversion single cycle", adcs, 0);
    endtask

    task automatic t_pwm_duty();
        arr = 2'b00;
        set_mode(4'b1100);
        load_duty(8'd2, 2'd1);
        for (int c = 0; c < 16; c++) begin
            pcnt = 10'(c); cyc();
            check("R8 duty 9 waveform", pin, (c < 9) ? 1 : 0);
        end
        dhi = 8'd0; dlo = 2'd2;
        pcnt = 10'd5; cyc();
        check("R8 duty held until period match", pin, 1);
        period = 1'b1; pcnt = 10'd15; cyc();
        period = 1'b0;
        pcnt = 10'd5; cyc();
        check("R8 new duty after match", pin, 0);
        pcnt = 10'd1; cyc();
        check("R8 new duty low count", pin, 1);
        load_duty(8'd0, 2'd0);
        pcnt = 10'd0; cyc();
        check("R8 zero duty never active", pin, 0);
        load_duty(8'hFF, 2'd3);
        pcnt = 10'd1022; cyc();
        check("R8 full duty active", pin, 1);
        pcnt = 10'd1023; cyc();
        check("R8 full duty last count", pin, 0);
    endtask

    task automatic t_polarity_bridge();
        set_mode(4'b1110);
        load_duty(8'd2, 2'd1);
        pcnt = 10'd3; cyc();
        check("R9 A active low on", pin, 4'b0000);
        pcnt = 10'd12; cyc();
        check("R9 A active low off", pin, 4'b0001);
        set_mode(4'b1100);
        arr = 2'b01; pcnt = 10'd3; cyc();
        check("R10 forward on", pin, 4'b1001);
        pcnt = 10'd12; cyc();
        check("R10 forward off", pin, 4'b0001);
        arr = 2'b11; pcnt = 10'd3; cyc();
        check("R10 reverse on", pin, 4'b0110);
        pcnt = 10'd12; cyc();
        check("R10 reverse off", pin, 4'b0100);
        arr = 2'b01;
        set_mode(4'b1111);
        pcnt = 10'd3; cyc();
        check("R9 forward all active low", pin, 4'b0110);
    endtask

    task automatic t_half_bridge();
        set_mode(4'b1100);
        arr = 2'b10; dead = 4'd3;
        load_duty(8'd1, 2'd0);
        pcnt = 10'd20;
        for (int i = 0; i < 5; i++) cyc();
        check("R11 steady B", pin, 4'b0010);
        pcnt = 10'd0;
        for (int i = 0; i < 3; i++) begin
            cyc();
            check("R11 gap before A", pin, 4'b0000);
        end
        cyc();
        check("R11 A after gap", pin, 4'b0001);
        pcnt = 10'd20;
        for (int i = 0; i < 3; i++) begin
            cyc();
            check("R11 gap before B", pin, 4'b0000);
        end
        cyc();
        check("R11 B after gap", pin, 4'b0010);
        dead = 4'd0;
        pcnt = 10'd0; cyc();
        check("R11 zero gap A", pin, 4'b0001);
        pcnt = 10'd20; cyc();
        check("R11 zero gap B", pin, 4'b0010);
        set_mode(4'b1101);
        check("R9 B/D active low steady", pin, 4'b0000);
        pcnt = 10'd0; cyc();
        check("R9 B/D active low inactive B", pin, 4'b0011);
    endtask

    task automatic t_disable_clears();
        set_mode(4'b0000);
        check("R1 disabled pins", pin, 0);
        arr = 2'b00;
        set_mode(4'b1100);
        pcnt = 10'd0; cyc();
        check("R1 duty cleared by disable", pin, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc();
        t_reset();
        t_single_edge();
        t_prescale();
        t_mode_change();
        t_compare();
        t_pwm_duty();
        t_polarity_bridge();
        t_half_bridge();
        t_disable_clears();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule